// File: doc/BRIEF.md
# Bounded Downward Stack Controller

This block keeps a last-in first-out stack in a small word-addressed store. A top-of-stack pointer register decides where the next word goes and where the next word comes from. Stored words never move between slots; each operation only moves the pointer. The stack grows toward address zero. A push lowers the pointer by one and then writes the word at the lowered address. A pop reads the word at the current pointer and then raises the pointer by one.

Two fixed addresses bound the pointer. 0x4000 means the stack is empty. 0x3FFB means the stack is full. This gives five 16-bit slots, at addresses 0x3FFF down to 0x3FFB. Every request first checks the pointer against these limits. The registered response reports success as 0 and failure as 1. A failed request leaves both the pointer and the stored words as they were. A client issues at most one request per cycle. In the next cycle it reads the status bit and, after a pop, the popped word.

Top module: `bounded_stack_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `tos` reads 0x4000, `resp_valid` is 0, `resp_fail` is 0 and `pop_data` is 0.
- R2: A push alone with `tos` not equal to 0x3FFB is accepted. `tos` drops by one at the next edge, and the following cycle shows `resp_valid`=1 and `resp_fail`=0.
- R3: A push alone with `tos` equal to 0x3FFB is an overflow. The following cycle shows `resp_fail`=1, `tos` is unchanged and no stored word changes.
- R4: A pop alone with `tos` not equal to 0x4000 is accepted. The following cycle shows `resp_fail`=0 and `pop_data` equal to the word stored at the old `tos` address, and `tos` has risen by one.
- R5: A pop alone with `tos` equal to 0x4000 is an underflow. The following cycle shows `resp_fail`=1 and `pop_data`=0, and `tos` is unchanged.
- R6: Popped words come back in the reverse of the order in which they were pushed.
- R7: If push and pop are asserted in the same cycle, the request is rejected. The following cycle shows `resp_fail`=1, and neither the pointer nor the store changes.
- R8: `resp_valid` is 1 in exactly those cycles that follow a cycle with any request. `resp_fail` and `pop_data` are 0 except in the cycle after a rejected request or after an accepted pop, respectively.
- R9: `tos` always lies between 0x3FFB and 0x4000 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request to push `push_data` |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | 16 | Word to store on a push |
| resp_valid | output | 1 | Response for last cycle's request is present |
| resp_fail | output | 1 | 1 = overflow, underflow or conflicting request |
| pop_data | output | 16 | Word returned by an accepted pop, else 0 |
| tos | output | 16 | Current top-of-stack pointer |

## Verification
The assertions assume that `push_req` and `pop_req` are known values at every clock edge after reset. They also assume that a client never expects a response in any cycle except the one directly after its request. The stimulus meets both assumptions in the same way. It drives every input on the falling edge from a fixed-seed random draw and holds it until the next falling edge. It also mixes in idle cycles and cycles with both requests high, so that rejection and the no-response cycles are both covered. Directed sequences fill the stack to its limit and drain it to empty, and they try one push past full and one pop past empty.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int PTR_W = 16;

  typedef logic [PTR_W-1:0] ptr_t;

  // Pointer value after an accepted push (pre-decrement).
  function automatic ptr_t ptr_after_push(input ptr_t p);
    return p - ptr_t'(1);
  endfunction

  // Pointer value after an accepted pop (post-increment).
  function automatic ptr_t ptr_after_pop(input ptr_t p);
    return p + ptr_t'(1);
  endfunction

  // Offset of an address inside the storage window.
  function automatic ptr_t slot_of(input ptr_t addr, input ptr_t lowest);
    return addr - lowest;
  endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter ptr_t EMPTY_ADDR = ptr_t'(16'h4000),
  parameter int   DEPTH      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_req,
  input  logic pop_req,
  output ptr_t tos,
  output logic push_ok,
  output logic pop_ok,
  output logic reject
);

  localparam ptr_t FULL_ADDR = EMPTY_ADDR - ptr_t'(DEPTH);

  logic at_empty;
  logic at_full;
  logic conflict;

  assign at_empty = (tos == EMPTY_ADDR);
  assign at_full  = (tos == FULL_ADDR);
  assign conflict = push_req && pop_req;

  assign push_ok = push_req && !pop_req && !at_full;
  assign pop_ok  = pop_req && !push_req && !at_empty;
  assign reject  = conflict || (push_req && at_full) || (pop_req && at_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos <= EMPTY_ADDR;
    end else if (push_ok) begin
      tos <= ptr_after_push(tos);
    end else if (pop_ok) begin
      tos <= ptr_after_pop(tos);
    end
  end

endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 5,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
    end
  end

endmodule

// File: rtl/stk_resp.sv
module stk_resp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_req,
  input  logic              reject,
  input  logic              pop_ok,
  input  logic [DATA_W-1:0] rd_data,
  output logic              resp_valid,
  output logic              resp_fail,
  output logic [DATA_W-1:0] pop_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fail  <= 1'b0;
      pop_data   <= '0;
    end else begin
      resp_valid <= any_req;
      resp_fail  <= reject;
      pop_data   <= pop_ok ? rd_data : '0;
    end
  end

endmodule

// File: rtl/bounded_stack_ctrl.sv
module bounded_stack_ctrl
  import stk_pkg::*;
#(
  parameter int   DATA_W     = 16,
  parameter int   DEPTH      = 5,
  parameter ptr_t EMPTY_ADDR = ptr_t'(16'h4000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_data,
  output logic              resp_valid,
  output logic              resp_fail,
  output logic [DATA_W-1:0] pop_data,
  output logic [PTR_W-1:0]  tos
);

  localparam int   IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam ptr_t FULL_ADDR = EMPTY_ADDR - ptr_t'(DEPTH);

  // Internal events, named for the checker.
  logic              push_ok;
  logic              pop_ok;
  logic              reject;
  logic              any_req;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;

  assign any_req = push_req || pop_req;
  assign wr_idx  = IDX_W'(slot_of(ptr_after_push(tos), FULL_ADDR));
  assign rd_idx  = IDX_W'(slot_of(tos, FULL_ADDR));

  stk_ptr #(
    .EMPTY_ADDR (EMPTY_ADDR),
    .DEPTH      (DEPTH)
  ) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .tos      (tos),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .reject   (reject)
  );

  stk_mem #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) mem_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_idx  (wr_idx),
    .wr_data (push_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  stk_resp #(
    .DATA_W (DATA_W)
  ) resp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_req    (any_req),
    .reject     (reject),
    .pop_ok     (pop_ok),
    .rd_data    (rd_data),
    .resp_valid (resp_valid),
    .resp_fail  (resp_fail),
    .pop_data   (pop_data)
  );

endmodule

// File: rtl/stk_checker.sv
module stk_checker
  import stk_pkg::*;
#(
  parameter int   DATA_W     = 16,
  parameter int   DEPTH      = 5,
  parameter ptr_t EMPTY_ADDR = ptr_t'(16'h4000)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_req,
  input logic              pop_req,
  input logic              resp_valid,
  input logic              resp_fail,
  input logic [DATA_W-1:0] pop_data,
  input ptr_t              tos,
  input logic              push_ok,
  input logic              pop_ok
);

  localparam ptr_t FULL_ADDR = EMPTY_ADDR - ptr_t'(DEPTH);

  a_r2_push_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && tos != FULL_ADDR) |=> (tos == $past(tos) - ptr_t'(1)) && !resp_fail);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && tos == FULL_ADDR) |=> resp_fail && $stable(tos));

  a_r4_pop_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && tos != EMPTY_ADDR) |=> (tos == $past(tos) + ptr_t'(1)) && !resp_fail);

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && tos == EMPTY_ADDR) |=> resp_fail && $stable(tos) && (pop_data == '0));

  a_r7_conflict_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> resp_fail && $stable(tos));

  a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req) |=> resp_valid);

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req || pop_req) |=> !resp_valid && !resp_fail);

  a_r8_data_only_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_ok |=> (pop_data == '0));

  a_r9_ptr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (tos <= EMPTY_ADDR) && (tos >= FULL_ADDR));

  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_ok && pop_ok));

endmodule

bind bounded_stack_ctrl stk_checker #(
  .DATA_W     (DATA_W),
  .DEPTH      (DEPTH),
  .EMPTY_ADDR (EMPTY_ADDR)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .resp_valid (resp_valid),
  .resp_fail  (resp_fail),
  .pop_data   (pop_data),
  .tos        (tos),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok)
);

// File: tb/bounded_stack_ctrl_tb_top.sv
module bounded_stack_ctrl_tb_top;

  localparam int          DW      = 16;
  localparam int          SLOTS   = 5;
  localparam logic [15:0] E_ADDR  = 16'h4000;
  localparam logic [15:0] F_ADDR  = 16'h3FFB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_req = 1'b0;
  logic          pop_req = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          resp_valid;
  logic          resp_fail;
  logic [DW-1:0] pop_data;
  logic [15:0]   tos;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Bench model of the stack.
  logic [15:0]   m_ptr;
  logic [DW-1:0] m_store [SLOTS];

  always #10 clk = ~clk;  // 50 MHz

  bounded_stack_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .push_data  (push_data),
    .resp_valid (resp_valid),
    .resp_fail  (resp_fail),
    .pop_data   (pop_data),
    .tos        (tos)
  );

  function automatic int model_slot(input logic [15:0] a);
    return int'(a) - int'(F_ADDR);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; expected outputs come from the bench model.
  task automatic step(input bit psh, input bit pp, input logic [DW-1:0] d, input string req);
    bit            e_valid;
    bit            e_fail;
    logic [DW-1:0] e_data;
    e_valid = psh || pp;
    e_fail  = 1'b0;
    e_data  = '0;
    if (psh && pp) begin
      e_fail = 1'b1;
    end else if (psh) begin
      if (m_ptr == F_ADDR) e_fail = 1'b1;
      else begin
        m_ptr = m_ptr - 16'd1;
        m_store[model_slot(m_ptr)] = d;
      end
    end else if (pp) begin
      if (m_ptr == E_ADDR) e_fail = 1'b1;
      else begin
        e_data = m_store[model_slot(m_ptr)];
        m_ptr  = m_ptr + 16'd1;
      end
    end
    push_req  = psh;
    pop_req   = pp;
    push_data = d;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0;
    pop_req  = 1'b0;
    check(req, "resp_valid", 32'(resp_valid), 32'(e_valid));
    check(req, "resp_fail", 32'(resp_fail), 32'(e_fail));
    check(req, "pop_data", 32'(pop_data), 32'(e_data));
    check(req, "tos", 32'(tos), 32'(m_ptr));
  endtask

  initial begin
    m_ptr = E_ADDR;
    for (int i = 0; i < SLOTS; i++) m_store[i] = '0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1", "tos in reset", 32'(tos), 32'(E_ADDR));
    check("R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "resp_fail after reset", 32'(resp_fail), 32'd0);
    check("R1", "pop_data after reset", 32'(pop_data), 32'd0);

    step(1'b0, 1'b1, 16'h0000, "R5");         // underflow on empty
    for (int i = 0; i < SLOTS; i++)
      step(1'b1, 1'b0, 16'hA000 + 16'(i), "R2");
    step(1'b1, 1'b0, 16'hDEAD, "R3");         // overflow at full
    step(1'b1, 1'b1, 16'hBEEF, "R7");         // conflict
    step(1'b0, 1'b0, 16'h0000, "R8");         // idle
    for (int i = 0; i < SLOTS; i++)
      step(1'b0, 1'b1, 16'h0000, "R6");       // reverse order, no 0xDEAD
    step(1'b0, 1'b1, 16'h0000, "R5");
    step(1'b1, 1'b0, 16'h1234, "R2");
    step(1'b1, 1'b1, 16'h5555, "R7");
    step(1'b0, 1'b1, 16'h0000, "R4");

    // Constrained random traffic with a fixed seed.
    begin
      int unsigned seed_v;
      seed_v = $urandom(32'd2024);
      for (int k = 0; k < 3000; k++) begin
        int unsigned r;
        r = $urandom % 8;
        if (r < 3)       step(1'b1, 1'b0, DW'($urandom), "R2");
        else if (r < 6)  step(1'b0, 1'b1, '0, "R4");
        else if (r == 6) step(1'b1, 1'b1, DW'($urandom), "R7");
        else             step(1'b0, 1'b0, '0, "R8");
        check("R9", "tos window", 32'((tos >= F_ADDR) && (tos <= E_ADDR)), 32'd1);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule